// File: doc/BRIEF.md
# Multi-Channel Thermal Sampling Sequencer

This block paces periodic measurements for up to four thermal sensor channels. A free-running timer opens a measurement round at a programmable interval. In each round the block visits every enabled channel in turn, lowest index first. For each channel it runs one or more sample slots. Each slot starts with an acquisition window, during which `acq_busy` is high. A one-cycle `conv_req` pulse then asks the external converter for a result, and the converter answers on `raw_valid`/`raw_data`.

The samples of one channel are summed and divided by a power of two, depending on the averaging setting. The result goes into that channel's data register. The channel's status flag is then raised, and `irq` follows the enabled status flags. Software drives everything through a simple byte-addressed register port with a write strobe and combinational read data. The analog front end and the conversion to degrees live outside the block.

Top module: `thermal_seq`

## Requirements
- R1: After reset, every data register, the status register, `irq` and `conv_req` are zero. The timing register reads back 0x01DF002F.
- R2: Measurement rounds start every (P+1) × UNIT_CLKS × N clocks. P is the period field at bits 31:12 of the period register (offset 0x08), N is the number of samples averaged, and UNIT_CLKS defaults to 4096.
- R3: The timing register (offset 0x00) sets the slot shape. Bits 15:0 hold A and bits 31:16 hold S. Each slot lasts S+1 clocks. `acq_busy` is high for its first A+1 clocks, and `conv_req` pulses for exactly one clock right after that.
- R4: Within a round, the enabled channels are visited in ascending index order. The enable register is at offset 0x04, with bit i for channel i, and disabled channels get no `conv_req`.
- R5: The averaging register (offset 0x30) takes an enable at bit 2 and a type at bits 1:0. When enabled, types 0, 1, 2 and 3 average 2, 4, 8 and 16 samples. When disabled, a single sample is used. The stored value is the sample sum shifted right by log2(N).
- R6: Only the first `raw_valid` after the start of a slot's conversion phase is accepted. A `raw_valid` while `acq_busy` is high is ignored.
- R7: Channel i's result reads at offset 0xC0 + 4·i, in bits 11:0. A channel that is not enabled keeps its previous value.
- R8: The status register (offset 0x20) has bit i set when channel i's result is stored. Writing 1 to a bit clears it, and writing 0 leaves it unchanged.
- R9: `irq` is high exactly when some status bit is set whose interrupt-enable bit is also set (offset 0x10, bit i for channel i).
- R10: The period field written at bits 31:12 of offset 0x08 reads back unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Byte address for reads and writes |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| raw_valid | input | 1 | Converter result strobe |
| raw_data | input | 12 | Converter result |
| conv_req | output | 1 | One-clock request to start a conversion |
| conv_chan | output | 2 | Channel being sampled |
| acq_busy | output | 1 | Acquisition window of the current slot |
| irq | output | 1 | Data-ready interrupt |

## Verification
The bench builds the block with four channels, 12-bit data and UNIT_CLKS set to 4 instead of 4096. With that setting, the 16-sample averaging mode and the round period both complete within a few thousand clocks. This puts every averaging type, channel skipping, injected acquisition-time strobes and the exact spacing of rounds and slots within reach of a short run. The converter model returns alternating values per channel, so the stored averages show the truncation of the right shift.

// File: rtl/thermal_seq_pkg.sv
package thermal_seq_pkg;

    typedef enum logic {
        SEQ_IDLE,
        SEQ_SLOT
    } seq_state_e;

    localparam logic [7:0] ADDR_TIMING = 8'h00;
    localparam logic [7:0] ADDR_ENABLE = 8'h04;
    localparam logic [7:0] ADDR_PERIOD = 8'h08;
    localparam logic [7:0] ADDR_IRQEN  = 8'h10;
    localparam logic [7:0] ADDR_STATUS = 8'h20;
    localparam logic [7:0] ADDR_AVG    = 8'h30;
    localparam logic [7:0] ADDR_DATA   = 8'hC0;

    localparam int PERIOD_W = 20;

    // log2 of the number of samples averaged per stored result
    function automatic logic [2:0] avg_shift(input logic avg_en, input logic [1:0] avg_type);
        return avg_en ? (3'd1 + {1'b0, avg_type}) : 3'd0;
    endfunction

endpackage

// File: rtl/thermal_seq_timer.sv
module thermal_seq_timer
    import thermal_seq_pkg::*;
#(
    parameter int UNIT_CLKS = 4096
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [PERIOD_W-1:0] period,
    input  logic [2:0]          shift,
    output logic                tick
);
    localparam int PRE_W = $clog2(UNIT_CLKS) + 5;

    typedef struct packed {
        logic [PRE_W-1:0]    pre;
        logic [PERIOD_W-1:0] units;
    } tmr_t;

    tmr_t tmr_d, tmr_q;
    logic [PRE_W-1:0] pre_lim;

    always_comb begin
        tmr_d   = tmr_q;
        tick    = 1'b0;
        pre_lim = (PRE_W'(UNIT_CLKS) << shift) - PRE_W'(1);
        if (tmr_q.pre >= pre_lim) begin
            tmr_d.pre = '0;
            if (tmr_q.units >= period) begin
                tmr_d.units = '0;
                tick        = 1'b1;
            end else begin
                tmr_d.units = tmr_q.units + PERIOD_W'(1);
            end
        end else begin
            tmr_d.pre = tmr_q.pre + PRE_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

endmodule

// File: rtl/thermal_seq_sched.sv
module thermal_seq_sched
    import thermal_seq_pkg::*;
#(
    parameter int NCH = 4,
    parameter int DW  = 12,
    localparam int CW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [NCH-1:0] chan_en,
    input  logic [15:0]    acq_len,
    input  logic [15:0]    slot_len,
    input  logic [2:0]     shift,
    input  logic           raw_valid,
    input  logic [DW-1:0]  raw_data,
    output logic           conv_req,
    output logic [CW-1:0]  conv_chan,
    output logic           acq_busy,
    output logic           pub_valid,
    output logic [CW-1:0]  pub_chan,
    output logic [DW-1:0]  pub_data
);
    localparam int AW = DW + 4;

    typedef struct packed {
        seq_state_e    st;
        logic [CW-1:0] chan;
        logic [15:0]   cnt;
        logic [4:0]    idx;
        logic [AW-1:0] acc;
        logic          got;
    } seq_t;

    seq_t seq_d, seq_q;

    logic          first_hit, next_hit, take, slot_end;
    logic [CW-1:0] first_ch, next_ch;
    logic [AW-1:0] acc_n;

    // lowest enabled channel overall, and lowest enabled above the current one
    always_comb begin
        first_hit = 1'b0;
        first_ch  = '0;
        next_hit  = 1'b0;
        next_ch   = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (chan_en[i]) begin
                first_hit = 1'b1;
                first_ch  = CW'(i);
                if (i > int'(seq_q.chan)) begin
                    next_hit = 1'b1;
                    next_ch  = CW'(i);
                end
            end
        end
    end

    always_comb begin
        seq_d     = seq_q;
        pub_valid = 1'b0;
        pub_chan  = seq_q.chan;
        pub_data  = '0;
        conv_chan = seq_q.chan;
        acq_busy  = (seq_q.st == SEQ_SLOT) && (seq_q.cnt <= acq_len);
        conv_req  = (seq_q.st == SEQ_SLOT) && ({1'b0, seq_q.cnt} == ({1'b0, acq_len} + 17'd1));
        take      = (seq_q.st == SEQ_SLOT) && raw_valid && !seq_q.got && (seq_q.cnt > acq_len);
        acc_n     = seq_q.acc + (take ? AW'(raw_data) : AW'(0));
        slot_end  = seq_q.cnt >= slot_len;
        case (seq_q.st)
            SEQ_IDLE: begin
                if (start && first_hit) begin
                    seq_d.st   = SEQ_SLOT;
                    seq_d.chan = first_ch;
                    seq_d.cnt  = '0;
                    seq_d.idx  = '0;
                    seq_d.acc  = '0;
                    seq_d.got  = 1'b0;
                end
            end
            default: begin
                seq_d.acc = acc_n;
                seq_d.got = seq_q.got | take;
                if (slot_end) begin
                    seq_d.cnt = '0;
                    seq_d.got = 1'b0;
                    if ((seq_q.idx + 5'd1) == (5'd1 << shift)) begin
                        pub_valid = 1'b1;
                        pub_data  = DW'(acc_n >> shift);
                        seq_d.acc = '0;
                        seq_d.idx = '0;
                        if (next_hit) seq_d.chan = next_ch;
                        else          seq_d.st   = SEQ_IDLE;
                    end else begin
                        seq_d.idx = seq_q.idx + 5'd1;
                    end
                end else begin
                    seq_d.cnt = seq_q.cnt + 16'd1;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '{st: SEQ_IDLE, default: '0};
        else        seq_q <= seq_d;
    end

endmodule

// File: rtl/thermal_seq_regs.sv
module thermal_seq_regs
    import thermal_seq_pkg::*;
#(
    parameter int NCH = 4,
    parameter int DW  = 12,
    localparam int CW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                we,
    input  logic [7:0]          addr,
    input  logic [31:0]         wdata,
    output logic [31:0]         rdata,
    input  logic                pub_valid,
    input  logic [CW-1:0]       pub_chan,
    input  logic [DW-1:0]       pub_data,
    output logic [15:0]         acq_len,
    output logic [15:0]         slot_len,
    output logic [NCH-1:0]      chan_en,
    output logic [PERIOD_W-1:0] period,
    output logic [2:0]          shift,
    output logic [NCH-1:0]      sts,
    output logic                irq
);
    typedef struct packed {
        logic [31:0]              timing;
        logic [NCH-1:0]           en;
        logic [PERIOD_W-1:0]      per;
        logic [NCH-1:0]           ien;
        logic [NCH-1:0]           sts;
        logic [2:0]               avg;
        logic [NCH-1:0][DW-1:0]   data;
    } reg_t;

    reg_t reg_d, reg_q;

    logic [7:0] doff;
    logic       is_data;

    always_comb begin
        reg_d = reg_q;
        if (we) begin
            case (addr)
                ADDR_TIMING: reg_d.timing = wdata;
                ADDR_ENABLE: reg_d.en     = wdata[NCH-1:0];
                ADDR_PERIOD: reg_d.per    = wdata[31:32-PERIOD_W];
                ADDR_IRQEN:  reg_d.ien    = wdata[NCH-1:0];
                ADDR_STATUS: reg_d.sts    = reg_q.sts & ~wdata[NCH-1:0];
                ADDR_AVG:    reg_d.avg    = wdata[2:0];
                default: ;
            endcase
        end
        // a new result wins over a clear in the same cycle
        if (pub_valid) begin
            reg_d.data[pub_chan] = pub_data;
            reg_d.sts[pub_chan]  = 1'b1;
        end
    end

    always_comb begin
        doff    = addr - ADDR_DATA;
        is_data = (addr >= ADDR_DATA) && (doff[1:0] == 2'b00) && (int'(doff[7:2]) < NCH);
        rdata   = '0;
        case (addr)
            ADDR_TIMING: rdata = reg_q.timing;
            ADDR_ENABLE: rdata = 32'(reg_q.en);
            ADDR_PERIOD: rdata = {reg_q.per, {(32-PERIOD_W){1'b0}}};
            ADDR_IRQEN:  rdata = 32'(reg_q.ien);
            ADDR_STATUS: rdata = 32'(reg_q.sts);
            ADDR_AVG:    rdata = 32'(reg_q.avg);
            default: if (is_data) rdata = 32'(reg_q.data[doff[CW+1:2]]);
        endcase
    end

    assign acq_len  = reg_q.timing[15:0];
    assign slot_len = reg_q.timing[31:16];
    assign chan_en  = reg_q.en;
    assign period   = reg_q.per;
    assign shift    = avg_shift(reg_q.avg[2], reg_q.avg[1:0]);
    assign sts      = reg_q.sts;
    assign irq      = |(reg_q.sts & reg_q.ien);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reg_q        <= '0;
            reg_q.timing <= {16'd479, 16'd47};
            reg_q.per    <= PERIOD_W'(365);
            reg_q.avg    <= 3'b101;
        end else begin
            reg_q <= reg_d;
        end
    end

endmodule

// File: rtl/thermal_seq.sv
module thermal_seq
    import thermal_seq_pkg::*;
#(
    parameter int NCH       = 4,
    parameter int DW        = 12,
    parameter int UNIT_CLKS = 4096,
    localparam int CW       = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_we,
    input  logic [7:0]    reg_addr,
    input  logic [31:0]   reg_wdata,
    output logic [31:0]   reg_rdata,
    input  logic          raw_valid,
    input  logic [DW-1:0] raw_data,
    output logic          conv_req,
    output logic [CW-1:0] conv_chan,
    output logic          acq_busy,
    output logic          irq
);
    logic [15:0]         acq_len, slot_len;
    logic [NCH-1:0]      chan_en, sts_q;
    logic [PERIOD_W-1:0] period;
    logic [2:0]          shift;
    logic                tick, pub_valid;
    logic [CW-1:0]       pub_chan;
    logic [DW-1:0]       pub_data;

    thermal_seq_regs #(.NCH(NCH), .DW(DW)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
        .rdata(reg_rdata), .pub_valid(pub_valid), .pub_chan(pub_chan), .pub_data(pub_data),
        .acq_len(acq_len), .slot_len(slot_len), .chan_en(chan_en), .period(period),
        .shift(shift), .sts(sts_q), .irq(irq)
    );

    thermal_seq_timer #(.UNIT_CLKS(UNIT_CLKS)) u_timer (
        .clk(clk), .rst_n(rst_n), .period(period), .shift(shift), .tick(tick)
    );

    thermal_seq_sched #(.NCH(NCH), .DW(DW)) u_sched (
        .clk(clk), .rst_n(rst_n), .start(tick), .chan_en(chan_en), .acq_len(acq_len),
        .slot_len(slot_len), .shift(shift), .raw_valid(raw_valid), .raw_data(raw_data),
        .conv_req(conv_req), .conv_chan(conv_chan), .acq_busy(acq_busy),
        .pub_valid(pub_valid), .pub_chan(pub_chan), .pub_data(pub_data)
    );

endmodule

// File: rtl/thermal_seq_chk.sv
module thermal_seq_chk #(
    parameter int NCH = 4,
    parameter int CW  = 2
) (
    input logic           clk,
    input logic           rst_n,
    input logic           conv_req,
    input logic           acq_busy,
    input logic           pub_valid,
    input logic [CW-1:0]  pub_chan,
    input logic [NCH-1:0] sts
);
    // R3
    conv_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        conv_req |=> !conv_req);

    // R3
    conv_after_acq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        conv_req |-> $past(acq_busy));

    // R6
    acq_conv_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(acq_busy && conv_req));

    // R8
    pub_sets_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pub_valid |=> sts[$past(pub_chan)]);

endmodule

bind thermal_seq thermal_seq_chk #(.NCH(NCH), .CW(CW)) u_chk (
    .clk(clk), .rst_n(rst_n), .conv_req(conv_req), .acq_busy(acq_busy),
    .pub_valid(pub_valid), .pub_chan(pub_chan), .sts(sts_q)
);

// File: tb/thermal_seq_bench.sv
module thermal_seq_bench;
    localparam int NCH = 4;
    localparam int DW  = 12;
    localparam int CW  = 2;

    // {en[4], avg[3], ien[4], base[12], step[12], spurious[1]}
    localparam logic [35:0] VECS [6] = '{
        {4'b1111, 3'b101, 4'b1111, 12'h100, 12'h010, 1'b0},
        {4'b0101, 3'b000, 4'b0001, 12'h050, 12'h007, 1'b0},
        {4'b1010, 3'b100, 4'b0100, 12'h200, 12'h021, 1'b1},
        {4'b1000, 3'b111, 4'b1000, 12'h3A0, 12'h00F, 1'b0},
        {4'b0011, 3'b110, 4'b0010, 12'h011, 12'h003, 1'b1},
        {4'b0001, 3'b001, 4'b0000, 12'h001, 12'h040, 1'b0}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_we = 1'b0;
    logic [7:0]    reg_addr = '0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic          raw_valid = 1'b0;
    logic [DW-1:0] raw_data = '0;
    logic          conv_req, acq_busy, irq;
    logic [CW-1:0] conv_chan;

    int checks = 0, fails = 0;
    int cyc = 0, pend = 0, pend_val = 0, arun = 0, last_acq = 0;
    int scnt [NCH];
    int olog [16];
    int nlog = 0;
    int tlog [8];
    int ntl = 0;
    int base = 0, step = 0;
    bit spur = 1'b0;
    int exp_data [NCH];

    always #4 clk = ~clk;

    thermal_seq #(.NCH(NCH), .DW(DW), .UNIT_CLKS(4)) u_thermal_seq (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .raw_valid(raw_valid),
        .raw_data(raw_data), .conv_req(conv_req), .conv_chan(conv_chan),
        .acq_busy(acq_busy), .irq(irq)
    );

    task automatic check(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, expv);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // converter model and monitors, acting on falling edges
    initial begin
        for (int c = 0; c < NCH; c++) scnt[c] = 0;
        forever begin
            @(negedge clk);
            cyc++;
            raw_valid = 1'b0;
            if (pend != 0) begin
                pend--;
                if (pend == 0) begin
                    raw_valid = 1'b1;
                    raw_data  = DW'(pend_val);
                end
            end
            if (conv_req) begin
                pend_val = base + int'(conv_chan) * 256 + (scnt[conv_chan][0] ? step : 0);
                scnt[conv_chan]++;
                pend = 2;
                if (nlog < 16 && (nlog == 0 || olog[nlog-1] != int'(conv_chan))) begin
                    olog[nlog] = int'(conv_chan);
                    nlog++;
                end
                if (ntl < 8) begin
                    tlog[ntl] = cyc;
                    ntl++;
                end
            end
            if (spur && acq_busy) begin
                raw_valid = 1'b1;
                raw_data  = 12'hFFF;
            end
            if (acq_busy) arun++;
            else if (arun != 0) begin
                last_acq = arun;
                arun = 0;
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual 0x%0h expected 0x%0h", 150000, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] r;
        for (int c = 0; c < NCH; c++) exp_data[c] = 0;

        // R1: reset state
        idle(3);
        rst_n = 1'b1;
        idle(2);
        check(conv_req == 1'b0, "R1 conv_req", int'(conv_req), 0);
        check(irq == 1'b0, "R1 irq", int'(irq), 0);
        rd(8'h20, r); check(r == 32'h0, "R1 status", r, 0);
        rd(8'h00, r); check(r == 32'h01DF002F, "R1 timing", r, 32'h01DF002F);
        for (int c = 0; c < NCH; c++) begin
            rd(8'(8'hC0 + 4 * c), r);
            check(r == 32'h0, "R1 data", r, 0);
        end

        // common setup: A=3, S=15, P=31
        wr(8'h00, {16'd15, 16'd3});
        wr(8'h08, 32'(31) << 12);
        rd(8'h08, r); check(r == (32'(31) << 12), "R10 period readback", r, 32'(31) << 12);

        for (int v = 0; v < 6; v++) begin
            logic [3:0] en, ien;
            logic [2:0] avg;
            int n, bits, polls, pos;
            logic [31:0] st;
            en   = VECS[v][35:32];
            avg  = VECS[v][31:29];
            ien  = VECS[v][28:25];
            wr(8'h04, 32'h0);
            idle(1100);
            wr(8'h30, 32'(avg));
            wr(8'h10, 32'(ien));
            wr(8'h20, 32'hF);
            base = int'(VECS[v][24:13]);
            step = int'(VECS[v][12:1]);
            spur = VECS[v][0];
            for (int c = 0; c < NCH; c++) scnt[c] = 0;
            nlog = 0;
            wr(8'h04, 32'(en));
            polls = 0;
            st = '0;
            while (((st[3:0] & en) != en) && polls < 8000) begin
                rd(8'h20, st);
                polls++;
            end
            wr(8'h04, 32'h0);
            spur = 1'b0;
            n = avg[2] ? (2 << avg[1:0]) : 1;
            // R4: visiting order is ascending over enabled channels
            bits = 0;
            pos = 0;
            for (int c = 0; c < NCH; c++) begin
                if (en[c]) begin
                    check(pos < nlog && olog[pos] == c, "R4 channel order",
                          (pos < nlog) ? olog[pos] : -1, c);
                    pos++;
                    bits++;
                end
            end
            check(nlog == bits, "R4 skipped channels", nlog, bits);
            // R5, R6, R7: stored values
            for (int c = 0; c < NCH; c++) begin
                if (en[c]) exp_data[c] = (base + c * 256 + ((n > 1) ? step / 2 : 0)) & 12'hFFF;
                rd(8'(8'hC0 + 4 * c), r);
                check(r == 32'(exp_data[c]), en[c] ? "R5 R6 averaged data" : "R7 disabled kept",
                      r, exp_data[c]);
            end
            // R8 and R9
            rd(8'h20, st);
            check(st[3:0] == en, "R8 status set", st, en);
            check(irq == |(en & ien), "R9 irq", int'(irq), int'(|(en & ien)));
            for (int c = 0; c < NCH; c++) begin
                if (en[c]) begin
                    wr(8'h20, 32'(1) << c);
                    rd(8'h20, st);
                    check(st[3:0] == (en & ~(4'(1) << c)), "R8 write-one-to-clear",
                          st, en & ~(4'(1) << c));
                    break;
                end
            end
            wr(8'h20, 32'h0);
            rd(8'h20, st);
            check(st[3:0] == (en & (en - 4'd1)), "R8 zero write no effect", st, en & (en - 4'd1));
            wr(8'h20, 32'hF);
            idle(1);
            check(irq == 1'b0, "R9 irq cleared", int'(irq), 0);
        end

        // R2 and R3: slot and round spacing with 2-sample averaging
        wr(8'h04, 32'h0);
        idle(1100);
        wr(8'h30, 32'h4);
        ntl = 0;
        wr(8'h04, 32'h1);
        for (int k = 0; k < 4000 && ntl < 3; k++) idle(1);
        wr(8'h04, 32'h0);
        check(ntl >= 3, "R2 rounds seen", ntl, 3);
        check(tlog[1] - tlog[0] == 16, "R3 slot length", tlog[1] - tlog[0], 16);
        check(tlog[2] - tlog[0] == 256, "R2 round period", tlog[2] - tlog[0], 256);
        check(last_acq == 4, "R3 acquisition width", last_acq, 4);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule